// File: doc/BRIEF.md
# Asynchronous Memory Write Sequencer

This block turns 32-bit word write requests into write cycles on an external asynchronous memory bus. Each request carries a chip-select index, a word address, a bank address, a data word and a code for the device's data width. Every access on the bus goes through four phases: an optional turnaround gap, then setup, strobe and hold. The length of each phase comes from a timing field set that is kept separately for each chip select.

A device narrower than 32 bits receives the word as two or four back-to-back accesses. The low-order lane goes first, and the byte address advances on each access. The turnaround gap depends on the request. It is left out when a write follows straight on from a write to the same chip select. It is raised to one cycle when the programmed count is zero. It never occurs between the accesses that make up one word.

The request side uses a valid/ready handshake. The requester holds its request stable until a single-cycle ready pulse, which marks the last hold cycle of the word. Each idle cycle in which the block samples a new request is a decision cycle, and the turnaround count starts after it.

Top module: `amem_wr_seq`

## Requirements
- R1: The output-enable pin `mem_oe_n` is high in every cycle.
- R2: A request sampled in an idle cycle drives its first chip-select low after 1+T cycles, where T is the turnaround count. T is the chip select's turnaround field, taken when that idle cycle samples the request.
- R3: T is 0 when the request is present in the first idle cycle after a ready pulse and targets the same chip select as the word just finished.
- R4: A turnaround field of 0 gives T=1. A request that follows straight on but targets a different chip select uses its own field, so that field's value holds with the zero case also raised to 1.
- R5: The per-chip-select timing field is {turnaround[14:13], hold[12:10], strobe[9:4], setup[3:0]}, with chip select i at bits [15*i+14:15*i] of `cfg_timing`. A field value N gives N+1 cycles of setup, strobe or hold.
- R6: During an access exactly one `mem_cs_n` bit is low, and `mem_rw` is low exactly when a chip select is low. `mem_we_n` is low throughout the strobe phase and high in setup and hold.
- R7: The width code 00 selects 8 bits and gives 4 accesses with the byte address stepping by 1. The code 01 selects 16 bits and gives 2 accesses stepping by 2. The codes 10 and 11 select 32 bits and give 1 access. The byte address of the first access is {word address, 2'b00}. Each access puts its lane on the low bits of `mem_dq`, with the low-order lane first and the upper bits at zero.
- R8: Between the accesses of one word, chip select and `mem_rw` stay low, and the next setup follows the hold directly. The setup, strobe and hold lengths are the ones taken at the word's first setup; a configuration change after that point does not affect the word.
- R9: `req_ready` is a single-cycle pulse in the last hold cycle of the word. In the next cycle every chip select and `mem_rw` are high. While no access runs, `mem_addr`, `mem_dq` and `mem_dq_oe` are zero.
- R10: `mem_ba` carries the request's bank address throughout its accesses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_valid | input | 1 | Write request present |
| req_ready | output | 1 | Word finished, request consumed |
| req_cs | input | CS_W | Target chip select index |
| req_addr | input | ADDR_W | Word address |
| req_bank | input | BA_W | Bank address |
| req_data | input | 32 | Write data word |
| req_width | input | 2 | Device width code |
| cfg_timing | input | NUM_CS*15 | Per-chip-select timing fields |
| mem_cs_n | output | NUM_CS | Chip selects, active low |
| mem_rw | output | 1 | Read/write, low for write |
| mem_we_n | output | 1 | Write enable, active low |
| mem_oe_n | output | 1 | Output enable, active low |
| mem_addr | output | ADDR_W+2 | Byte address |
| mem_ba | output | BA_W | Bank address |
| mem_dq | output | 32 | Write data lane |
| mem_dq_oe | output | 1 | Data bus drive enable |

## Verification
The assertions check the pin relations that must hold in every cycle. These are: output enable stays high, read/write follows chip select, at most one chip select is active, write enable is active only under a chip select, the ready pulse lasts one cycle and releases the bus, and the bus is quiet between words. Chip select is also checked to stay fixed inside a word. Phase lengths, the turnaround count chosen for each case, the order of byte lanes and addresses, and the fact that timing is not reloaded within a word can only be shown by the bench's scenarios. The bench measures each of these against its own model of the configuration.

// File: rtl/amem_wr_seq.sv
module amem_wr_seq #(
  parameter int NUM_CS = 4,
  parameter int CS_W   = $clog2(NUM_CS),
  parameter int ADDR_W = 20,
  parameter int BA_W   = 2,
  parameter int TA_W   = 2,
  parameter int SU_W   = 4,
  parameter int ST_W   = 6,
  parameter int HD_W   = 3
) (
  input  logic                                         clk,
  input  logic                                         rst_n,
  input  logic                                         req_valid,
  output logic                                         req_ready,
  input  logic [CS_W-1:0]                              req_cs,
  input  logic [ADDR_W-1:0]                            req_addr,
  input  logic [BA_W-1:0]                              req_bank,
  input  logic [31:0]                                  req_data,
  input  logic [1:0]                                   req_width,
  input  logic [NUM_CS*(TA_W+SU_W+ST_W+HD_W)-1:0]      cfg_timing,
  output logic [NUM_CS-1:0]                            mem_cs_n,
  output logic                                         mem_rw,
  output logic                                         mem_we_n,
  output logic                                         mem_oe_n,
  output logic [ADDR_W+1:0]                            mem_addr,
  output logic [BA_W-1:0]                              mem_ba,
  output logic [31:0]                                  mem_dq,
  output logic                                         mem_dq_oe
);
  localparam int FW = TA_W + SU_W + ST_W + HD_W;
  localparam int M1 = (SU_W > ST_W) ? SU_W : ST_W;
  localparam int M2 = (HD_W > TA_W) ? HD_W : TA_W;
  localparam int CW = (M1 > M2) ? M1 : M2;

  typedef enum logic [2:0] {S_IDLE, S_TURN, S_SETUP, S_STRB, S_HOLD} st_t;

  st_t               st;
  logic [CW-1:0]     cnt;
  logic [CS_W-1:0]   cs_q, last_cs;
  logic              chain;
  logic [ADDR_W+1:0] a_q;
  logic [BA_W-1:0]   ba_q;
  logic [31:0]       d_q;
  logic [1:0]        w_q, beat;
  logic [SU_W-1:0]   su_q;
  logic [ST_W-1:0]   stb_q;
  logic [HD_W-1:0]   hd_q;

  logic [FW-1:0] req_fld, cur_fld, sel_fld;
  logic [TA_W-1:0] ta_sel;
  logic [SU_W-1:0] su_sel;
  logic [ST_W-1:0] st_sel;
  logic [HD_W-1:0] hd_sel;
  logic skip_ta, last_beat, hold_done, active;

  assign req_fld = cfg_timing[req_cs*FW +: FW];
  assign cur_fld = cfg_timing[cs_q*FW +: FW];
  assign sel_fld = (st == S_IDLE) ? req_fld : cur_fld;
  assign su_sel  = sel_fld[SU_W-1:0];
  assign st_sel  = sel_fld[SU_W +: ST_W];
  assign hd_sel  = sel_fld[SU_W+ST_W +: HD_W];
  assign ta_sel  = sel_fld[SU_W+ST_W+HD_W +: TA_W];

  assign skip_ta   = chain && (req_cs == last_cs);
  assign last_beat = (w_q == 2'd0) ? (beat == 2'd3) :
                     (w_q == 2'd1) ? (beat == 2'd1) : 1'b1;
  assign hold_done = (st == S_HOLD) && (cnt == '0);
  assign req_ready = hold_done && last_beat;
  assign active    = (st == S_SETUP) || (st == S_STRB) || (st == S_HOLD);

  assign mem_cs_n  = active ? ~(NUM_CS'(1) << cs_q) : '1;
  assign mem_rw    = !active;
  assign mem_we_n  = (st != S_STRB);
  assign mem_oe_n  = 1'b1;
  assign mem_addr  = active ? a_q : '0;
  assign mem_ba    = active ? ba_q : '0;
  assign mem_dq_oe = active;
  assign mem_dq    = !active        ? 32'd0 :
                     (w_q == 2'd0)  ? {24'd0, d_q[7:0]} :
                     (w_q == 2'd1)  ? {16'd0, d_q[15:0]} : d_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st      <= S_IDLE;
      cnt     <= '0;
      cs_q    <= '0;
      last_cs <= '0;
      chain   <= 1'b0;
      a_q     <= '0;
      ba_q    <= '0;
      d_q     <= '0;
      w_q     <= '0;
      beat    <= '0;
      su_q    <= '0;
      stb_q   <= '0;
      hd_q    <= '0;
    end else begin
      case (st)
        S_IDLE: begin
          chain <= 1'b0;
          if (req_valid) begin
            cs_q <= req_cs;
            a_q  <= {req_addr, 2'b00};
            ba_q <= req_bank;
            d_q  <= req_data;
            w_q  <= req_width;
            beat <= '0;
            if (skip_ta) begin
              st    <= S_SETUP;
              su_q  <= su_sel;
              stb_q <= st_sel;
              hd_q  <= hd_sel;
              cnt   <= CW'(su_sel);
            end else begin
              st  <= S_TURN;
              cnt <= (ta_sel == '0) ? '0 : CW'(ta_sel) - CW'(1);
            end
          end
        end
        S_TURN: begin
          if (cnt == '0) begin
            st    <= S_SETUP;
            su_q  <= su_sel;
            stb_q <= st_sel;
            hd_q  <= hd_sel;
            cnt   <= CW'(su_sel);
          end else begin
            cnt <= cnt - CW'(1);
          end
        end
        S_SETUP: begin
          if (cnt == '0) begin
            st  <= S_STRB;
            cnt <= CW'(stb_q);
          end else begin
            cnt <= cnt - CW'(1);
          end
        end
        S_STRB: begin
          if (cnt == '0) begin
            st  <= S_HOLD;
            cnt <= CW'(hd_q);
          end else begin
            cnt <= cnt - CW'(1);
          end
        end
        S_HOLD: begin
          if (cnt != '0) begin
            cnt <= cnt - CW'(1);
          end else if (last_beat) begin
            st      <= S_IDLE;
            chain   <= 1'b1;
            last_cs <= cs_q;
          end else begin
            st   <= S_SETUP;
            cnt  <= CW'(su_q);
            beat <= beat + 2'd1;
            a_q  <= a_q + ((ADDR_W+2)'(1) << w_q);
            d_q  <= d_q >> (6'd8 << w_q);
          end
        end
        default: st <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/amem_wr_seq_chk.sv
module amem_wr_seq_chk #(
  parameter int NUM_CS = 4,
  parameter int ADDR_W = 20
) (
  input logic              clk,
  input logic              rst_n,
  input logic              req_ready,
  input logic [NUM_CS-1:0] mem_cs_n,
  input logic              mem_rw,
  input logic              mem_we_n,
  input logic              mem_oe_n,
  input logic [ADDR_W+1:0] mem_addr,
  input logic [31:0]       mem_dq,
  input logic              mem_dq_oe
);
  logic busy;
  assign busy = !(&mem_cs_n);

  AST_OE_STAYS_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    mem_oe_n == 1'b1); // R1
  AST_RW_TRACKS_CS: assert property (@(posedge clk) disable iff (!rst_n)
    busy == !mem_rw); // R6
  AST_ONE_CS: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(~mem_cs_n)); // R6
  AST_WE_UNDER_CS: assert property (@(posedge clk) disable iff (!rst_n)
    !mem_we_n |-> busy); // R6
  AST_READY_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |=> !req_ready); // R9
  AST_RELEASE_AFTER_READY: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |=> (&mem_cs_n && mem_rw)); // R9
  AST_BUS_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (mem_addr == '0 && mem_dq == '0 && !mem_dq_oe)); // R9
  AST_CS_HELD_IN_WORD: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !req_ready) |=> $stable(mem_cs_n)); // R8
endmodule

bind amem_wr_seq amem_wr_seq_chk #(.NUM_CS(NUM_CS), .ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .req_ready(req_ready), .mem_cs_n(mem_cs_n),
  .mem_rw(mem_rw), .mem_we_n(mem_we_n), .mem_oe_n(mem_oe_n),
  .mem_addr(mem_addr), .mem_dq(mem_dq), .mem_dq_oe(mem_dq_oe)
);

// File: tb/amem_wr_seq_bench.sv
module amem_wr_seq_bench;
  localparam int NCS = 4;
  localparam int AW  = 20;
  localparam int FW  = 15;

  logic clk = 0, rst_n = 0;
  logic req_valid = 0, req_ready;
  logic [1:0] req_cs = 0, req_bank = 0, req_width = 0;
  logic [AW-1:0] req_addr = 0;
  logic [31:0] req_data = 0;
  logic [NCS*FW-1:0] cfg_timing = 0;
  logic [NCS-1:0] mem_cs_n;
  logic mem_rw, mem_we_n, mem_oe_n, mem_dq_oe;
  logic [AW+1:0] mem_addr;
  logic [1:0] mem_ba;
  logic [31:0] mem_dq;

  amem_wr_seq u_amem_wr_seq (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_cs(req_cs), .req_addr(req_addr), .req_bank(req_bank), .req_data(req_data),
    .req_width(req_width), .cfg_timing(cfg_timing), .mem_cs_n(mem_cs_n),
    .mem_rw(mem_rw), .mem_we_n(mem_we_n), .mem_oe_n(mem_oe_n), .mem_addr(mem_addr),
    .mem_ba(mem_ba), .mem_dq(mem_dq), .mem_dq_oe(mem_dq_oe)
  );

  always #10 clk = ~clk;

  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  int n_chk = 0, n_fail = 0;

  task automatic chk(bit ok, string req, string what, longint act, longint exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: got %0h expected %0h", req, what, act, exp);
    end
  endtask

  typedef struct {
    int cs; logic [AW+1:0] addr; logic [31:0] dq; logic [1:0] ba;
    int pre; int strb; int hold; bit first; bit last; int low_cyc;
  } item_t;
  item_t q[$];

  int ta_m[NCS], su_m[NCS], st_m[NCS], hd_m[NCS];
  int last_rdy_cyc = -10, last_cs_m = -1;

  task automatic set_cfg(int cs, int ta, int su, int st, int hd);
    ta_m[cs] = ta; su_m[cs] = su; st_m[cs] = st; hd_m[cs] = hd;
    cfg_timing[cs*FW +: FW] = {ta[1:0], hd[2:0], st[5:0], su[3:0]};
  endtask

  task automatic send(int cs, int addr, int ba, logic [31:0] data, int w);
    int c0, ta_eff, n, step;
    item_t it;
    req_cs = cs[1:0]; req_addr = addr[AW-1:0]; req_bank = ba[1:0];
    req_data = data; req_width = w[1:0]; req_valid = 1;
    c0 = cyc;
    if (c0 == last_rdy_cyc + 1 && cs == last_cs_m) ta_eff = 0;
    else ta_eff = (ta_m[cs] == 0) ? 1 : ta_m[cs];
    n = (w == 0) ? 4 : (w == 1) ? 2 : 1;
    step = (w == 0) ? 1 : 2;
    for (int k = 0; k < n; k++) begin
      it.cs = cs;
      it.addr = {addr[AW-1:0], 2'b00} + (AW+2)'(k * step);
      it.dq = (w == 0) ? ((data >> (8*k)) & 32'hFF) :
              (w == 1) ? ((data >> (16*k)) & 32'hFFFF) : data;
      it.ba = ba[1:0];
      it.pre = (k == 0) ? su_m[cs] + 1 : hd_m[cs] + 1 + su_m[cs] + 1;
      it.strb = st_m[cs] + 1;
      it.hold = hd_m[cs] + 1;
      it.first = (k == 0);
      it.last = (k == n - 1);
      it.low_cyc = c0 + 1 + ta_eff;
      q.push_back(it);
    end
    do @(negedge clk); while (!req_ready);
    last_rdy_cyc = cyc; last_cs_m = cs;
    @(negedge clk);
    req_valid = 0;
  endtask

  // monitor / scoreboard
  item_t cur;
  bit p_act = 0, p_we = 1;
  int hi = 0, lo = 0, first_low = 0;
  always @(negedge clk) if (rst_n) begin
    automatic bit act = !(&mem_cs_n);
    chk(mem_oe_n == 1'b1, "R1", "output enable", mem_oe_n, 1);
    chk(mem_rw == !act, "R6", "rw vs cs", mem_rw, !act);
    if (act && !p_act) begin first_low = cyc; hi = 0; end
    if (act) begin
      if (!mem_we_n) begin
        if (p_we) begin
          if (q.size() == 0) chk(0, "R7", "unexpected access", 1, 0);
          else begin
            cur = q.pop_front();
            chk(mem_cs_n == ~(4'(1) << cur.cs), "R6", "chip select", mem_cs_n, ~(4'(1) << cur.cs));
            chk(mem_addr == cur.addr, "R7", "byte address", mem_addr, cur.addr);
            chk(mem_dq == cur.dq, "R7", "data lane", mem_dq, cur.dq);
            chk(mem_ba == cur.ba, "R10", "bank address", mem_ba, cur.ba);
            chk(hi == cur.pre, cur.first ? "R5" : "R8", "cycles before strobe", hi, cur.pre);
            if (cur.first)
              chk(first_low == cur.low_cyc, "R2", "turnaround (R3/R4 cases)", first_low, cur.low_cyc);
          end
          lo = 1;
        end else lo++;
      end else begin
        if (!p_we) begin
          chk(lo == cur.strb, "R5", "strobe length", lo, cur.strb);
          hi = 1;
        end else hi++;
      end
    end else if (p_act) begin
      chk(cur.last, "R8", "chip select released mid-word", 0, 1);
      chk(hi == cur.hold, "R5", "final hold length", hi, cur.hold);
    end
    p_act = act; p_we = mem_we_n;
  end

  initial begin
    repeat (100000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end

  initial begin
    set_cfg(0, 2, 1, 2, 0);
    set_cfg(1, 0, 0, 0, 1);
    set_cfg(2, 3, 2, 1, 2);
    set_cfg(3, 1, 3, 4, 0);
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk(mem_cs_n == 4'hF, "R9", "reset cs", mem_cs_n, 4'hF);
    chk(mem_rw && mem_we_n && !req_ready, "R9", "reset strobes", {mem_rw, mem_we_n, req_ready}, 3'b110);
    chk(mem_addr == 0 && mem_dq == 0 && !mem_dq_oe, "R9", "reset bus quiet", mem_addr, 0);

    send(0, 'h123, 1, 32'hA1B2C3D4, 2);                 // R2 32-bit
    repeat (3) @(negedge clk);
    send(1, 'h040, 2, 32'h11223344, 1);                 // R4 ta=0, 16-bit
    send(1, 'h041, 3, 32'h55667788, 0);                 // R3 chained same cs, 8-bit
    send(2, 'hFFFFF, 0, 32'hDEADBEEF, 3);               // R4 chained other cs, code 11
    repeat (2) @(negedge clk);
    fork
      send(3, 'h0AA, 1, 32'hCAFEF00D, 0);               // R8 no reload mid-word
      begin
        wait (mem_cs_n != 4'hF);
        @(negedge clk);
        set_cfg(3, 2, 0, 0, 3);
      end
    join
    send(3, 'h0AB, 2, 32'h0BADF00D, 1);                 // R3 with new timing
    repeat (4) @(negedge clk);
    send(3, 'h0AC, 0, 32'h12345678, 1);                 // R2 same cs after a gap
    repeat (3) @(negedge clk);
    chk(q.size() == 0, "R7", "accesses outstanding", q.size(), 0);
    chk(mem_cs_n == 4'hF && mem_rw, "R9", "bus released", mem_cs_n, 4'hF);
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end
endmodule